// File: doc/BRIEF.md
# Memory Response Ordering Buffer

This block sits between the issue side of a global memory pipeline and its retire stage. It tracks every outstanding load and store by sequence number and decides when each completion may be handed to the retire stage. A static mode input picks one of two release rules. In in-order mode, a completion leaves only when every older request has already left. In out-of-order mode, completions leave in the order they came back from memory.

The issue side presents a sequence number and a load/store flag, gated by a ready output. That ready output accounts for the requests already outstanding and for a count of slots the caller still has reserved. The memory side returns completions by sequence number only. The block looks up the request type in its own tag table. In out-of-order mode, it queues the completion in a load FIFO or a store FIFO. In in-order mode, it only marks the table entry as done. The retire side uses a valid/ready handshake.

Top module: `mem_resp_orderer`

## Requirements
- R1: After reset, `ret_valid`, `ld_inflight`, `st_inflight` and `err_unknown_tag` are 0, and `iss_ready`, `rsp_ld_ready` and `rsp_st_ready` are 1.
- R2: `iss_ready` is 1 only when `ld_inflight + st_inflight + iss_pend` is strictly less than QSIZE.
- R3: In in-order mode (`cfg_in_order`=1), completions retire in strictly increasing sequence order. A younger request that is done waits while any older request is not done.
- R4: In in-order mode, a response changes nothing at the retire port except through the oldest entry. `ret_valid` stays 0 until the oldest outstanding request has received its response.
- R5: In out-of-order mode, completions retire in arrival order across both loads and stores. `ret_is_store` is 1 for a store and 0 for a load.
- R6: In out-of-order mode, `rsp_ld_ready` (`rsp_st_ready`) is 0 exactly while the load (store) FIFO holds QSIZE completions that have not retired.
- R7: `ld_inflight` and `st_inflight` rise by one on an accepted issue of their type and fall by one on a retire of their type. When both events happen in the same cycle, the count is unchanged.
- R8: A response whose sequence number is not outstanding, or that repeats an earlier response, leaves the block's state unchanged and sets `err_unknown_tag`. Only reset clears `err_unknown_tag`.
- R9: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid` and `ret_seq` hold in the next cycle.
- R10: After reset, issued sequence numbers start at 0 and rise by one per accepted issue. The tag table has ORD_DEPTH entries, each holding the request whose sequence number has that entry's index in its low bits. `iss_ready` is 0 while the entry for the next sequence number is still occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_in_order | input | 1 | 1: release in program order; 0: release in arrival order; change only under reset |
| iss_valid | input | 1 | Issue request present |
| iss_seq | input | SEQ_W | Sequence number of the issued request |
| iss_is_store | input | 1 | 1 for a store, 0 for a load |
| iss_pend | input | CNT_W | Slots the caller has reserved but not yet issued |
| iss_ready | output | 1 | Issue accepted this cycle when high |
| rsp_valid | input | 1 | Completion present |
| rsp_seq | input | SEQ_W | Sequence number of the completed request |
| rsp_ld_ready | output | 1 | Load completion FIFO has room |
| rsp_st_ready | output | 1 | Store completion FIFO has room |
| ret_valid | output | 1 | A completion is offered to the retire stage |
| ret_ready | input | 1 | Retire stage takes the offered completion |
| ret_seq | output | SEQ_W | Sequence number of the offered completion |
| ret_is_store | output | 1 | Type of the offered completion |
| ld_inflight | output | CNT_W | Loads issued and not yet retired |
| st_inflight | output | CNT_W | Stores issued and not yet retired |
| err_unknown_tag | output | 1 | Sticky flag: a response matched no outstanding request |

## Verification
The bench builds the block with QSIZE=4, ORD_DEPTH=4 and SEQ_W=6. With a queue of four, a few issues are enough to close `iss_ready`, to fill the load completion FIFO, and to test the reservation count against the limit. A tag table only as deep as the queue lets a single stalled old request block the next sequence number's entry in out-of-order mode. This makes the entry-busy stall reachable after a handful of cycles.

// File: rtl/mro_pkg.sv
// Package: shared types for the memory response ordering buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mro_pkg;

    // Request kind, as carried on the issue port and held in the tag table.
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } req_kind_e;

    // Release rule chosen by the static mode input.
    typedef enum logic {
        REL_ARRIVAL = 1'b0,
        REL_PROGRAM = 1'b1
    } rel_mode_e;

endpackage

// File: rtl/mro_resp_fifo.sv
// Module: mro_resp_fifo
// Holds completions in arrival order for one request kind.
// Assumes the caller never pushes into a full FIFO unless it pops in the same cycle.
module mro_resp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         not_empty,
    output logic [W-1:0] head,
    output logic         has_room
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    assign not_empty = (count != '0);
    assign has_room  = (count < CW'(DEPTH));
    assign head      = mem[rd_ptr];

    // Store a pushed completion at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (has_room || pop));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/mro_inflight_ctr.sv
// Module: mro_inflight_ctr
// Counts outstanding requests of one kind.
// Assumes that dec is raised only while at least one request is outstanding.
module mro_inflight_ctr #(
    parameter int MAX = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Net change per cycle: +1, -1 or none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(inc) - W'(dec);
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(MAX));
    p_cnt_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (cnt != '0));
    p_cnt_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/mro_tag_table.sv
// Module: mro_tag_table
// Circular table of outstanding requests, indexed by the low bits of the
// sequence number. Each entry holds valid, done, kind and the full sequence number.
// Assumes: DEPTH is a power of two below 2**SEQ_W, and issues arrive with
// consecutive sequence numbers that start at zero after reset.
module mro_tag_table #(
    parameter int SEQ_W = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_fire,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             iss_store,
    input  logic             rsp_valid,
    input  logic [SEQ_W-1:0] rsp_seq,
    input  logic             clr_en,
    input  logic [SEQ_W-1:0] clr_seq,
    input  logic             adv_head,
    output logic             slot_free,
    output logic             rsp_hit,
    output logic             rsp_hit_store,
    output logic             head_rdy,
    output logic [SEQ_W-1:0] head_seq,
    output logic             head_store
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] done;
    logic [DEPTH-1:0] kind;
    logic [SEQ_W-1:0] seqm [DEPTH];
    logic [SEQ_W-1:0] exp_seq;
    logic [IW-1:0]    head;

    logic [IW-1:0] iss_idx;
    logic [IW-1:0] rsp_idx;
    logic [IW-1:0] clr_idx;

    assign iss_idx = iss_seq[IW-1:0];
    assign rsp_idx = rsp_seq[IW-1:0];
    assign clr_idx = clr_seq[IW-1:0];

    // The next sequence number needs its own entry to be free.
    assign slot_free     = !vld[exp_seq[IW-1:0]];
    // A response matches only a live, not yet completed entry with the same full number.
    assign rsp_hit       = rsp_valid && vld[rsp_idx] && !done[rsp_idx]
                           && (seqm[rsp_idx] == rsp_seq);
    assign rsp_hit_store = kind[rsp_idx];
    assign head_rdy      = vld[head] && done[head];
    assign head_seq      = seqm[head];
    assign head_store    = kind[head];

    // Per-entry state: set on issue, mark done on response, drop on retire.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i]  <= 1'b0;
                done[i] <= 1'b0;
                kind[i] <= 1'b0;
                seqm[i] <= '0;
            end else if (iss_fire && (iss_idx == IW'(i))) begin
                vld[i]  <= 1'b1;
                done[i] <= 1'b0;
                kind[i] <= iss_store;
                seqm[i] <= iss_seq;
            end else begin
                if (rsp_hit && (rsp_idx == IW'(i))) begin
                    done[i] <= 1'b1;
                end
                if (clr_en && (clr_idx == IW'(i))) begin
                    vld[i] <= 1'b0;
                end
            end
        end
    end

    // Expected next sequence number and the oldest-entry pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_seq <= '0;
            head    <= '0;
        end else begin
            if (iss_fire) begin
                exp_seq <= iss_seq + 1'b1;
            end
            if (adv_head) begin
                head <= head + 1'b1;
            end
        end
    end

    p_issue_in_sequence_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (iss_seq == exp_seq));
    p_issue_slot_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> !vld[iss_idx]);
    p_retire_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (vld[clr_idx] && done[clr_idx] && (seqm[clr_idx] == clr_seq)));
    p_response_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !(clr_en && (clr_idx == rsp_idx))) |=> done[$past(rsp_idx)]);
endmodule

// File: rtl/mem_resp_orderer.sv
// Module: mem_resp_orderer (top)
// Tracks outstanding global memory requests and releases their completions
// to a retire stage. In program-order mode, it releases from the oldest table
// entry once that entry is done. In arrival-order mode, it releases from
// separate load and store FIFOs, taking whichever head arrived first (the
// load wins a tie).
// Assumes cfg_in_order changes only under reset, and that issues carry
// consecutive sequence numbers starting at zero.
module mem_resp_orderer #(
    parameter int SEQ_W     = 8,
    parameter int QSIZE     = 8,
    parameter int ORD_DEPTH = 16,
    parameter int CNT_W     = $clog2(QSIZE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_in_order,
    input  logic             iss_valid,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             iss_is_store,
    input  logic [CNT_W-1:0] iss_pend,
    output logic             iss_ready,
    input  logic             rsp_valid,
    input  logic [SEQ_W-1:0] rsp_seq,
    output logic             rsp_ld_ready,
    output logic             rsp_st_ready,
    output logic             ret_valid,
    input  logic             ret_ready,
    output logic [SEQ_W-1:0] ret_seq,
    output logic             ret_is_store,
    output logic [CNT_W-1:0] ld_inflight,
    output logic [CNT_W-1:0] st_inflight,
    output logic             err_unknown_tag
);
    import mro_pkg::*;

    localparam int STAMP_W = $clog2(QSIZE) + 2;
    localparam int FW      = SEQ_W + STAMP_W;
    localparam int SUM_W   = CNT_W + 2;

    rel_mode_e mode;
    assign mode = rel_mode_e'(cfg_in_order);

    logic             iss_fire, ret_fire;
    logic             slot_free, rsp_hit, rsp_hit_store;
    logic             head_rdy, head_store;
    logic [SEQ_W-1:0] head_seq;
    logic [SUM_W-1:0] demand;

    // Issue gate: outstanding plus reserved must stay below the queue size.
    assign demand    = SUM_W'(ld_inflight) + SUM_W'(st_inflight) + SUM_W'(iss_pend);
    assign iss_ready = (demand < SUM_W'(QSIZE)) && slot_free;
    assign iss_fire  = iss_valid && iss_ready;

    mro_tag_table #(.SEQ_W(SEQ_W), .DEPTH(ORD_DEPTH)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .iss_fire      (iss_fire),
        .iss_seq       (iss_seq),
        .iss_store     (iss_is_store),
        .rsp_valid     (rsp_valid),
        .rsp_seq       (rsp_seq),
        .clr_en        (ret_fire),
        .clr_seq       (ret_seq),
        .adv_head      (ret_fire && (mode == REL_PROGRAM)),
        .slot_free     (slot_free),
        .rsp_hit       (rsp_hit),
        .rsp_hit_store (rsp_hit_store),
        .head_rdy      (head_rdy),
        .head_seq      (head_seq),
        .head_store    (head_store)
    );

    // Arrival-order path: two FIFOs tagged with an arrival stamp.
    logic [STAMP_W-1:0] stamp;
    logic               push_ld, push_st, pop_ld, pop_st;
    logic               ld_v, st_v, pick_st;
    logic [FW-1:0]      ld_head, st_head;
    logic [STAMP_W-1:0] stamp_gap;

    assign push_ld = rsp_hit && (mode == REL_ARRIVAL) && (rsp_hit_store == KIND_LOAD);
    assign push_st = rsp_hit && (mode == REL_ARRIVAL) && (rsp_hit_store == KIND_STORE);

    // Arrival stamp advances once per queued completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (push_ld || push_st) begin
            stamp <= stamp + 1'b1;
        end
    end

    mro_resp_fifo #(.DEPTH(QSIZE), .W(FW)) u_ld_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ld),
        .push_data ({rsp_seq, stamp}),
        .pop       (pop_ld),
        .not_empty (ld_v),
        .head      (ld_head),
        .has_room  (rsp_ld_ready)
    );

    mro_resp_fifo #(.DEPTH(QSIZE), .W(FW)) u_st_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_st),
        .push_data ({rsp_seq, stamp}),
        .pop       (pop_st),
        .not_empty (st_v),
        .head      (st_head),
        .has_room  (rsp_st_ready)
    );

    // Store head wins only when it is strictly older (negative wrapped gap).
    assign stamp_gap = st_head[STAMP_W-1:0] - ld_head[STAMP_W-1:0];
    assign pick_st   = st_v && (!ld_v || stamp_gap[STAMP_W-1]);

    // Retire port mux by mode.
    always_comb begin
        if (mode == REL_PROGRAM) begin
            ret_valid    = head_rdy;
            ret_seq      = head_seq;
            ret_is_store = head_store;
        end else begin
            ret_valid    = ld_v || st_v;
            ret_seq      = pick_st ? st_head[FW-1:STAMP_W] : ld_head[FW-1:STAMP_W];
            ret_is_store = pick_st;
        end
    end

    assign ret_fire = ret_valid && ret_ready;
    assign pop_ld   = ret_fire && (mode == REL_ARRIVAL) && !pick_st;
    assign pop_st   = ret_fire && (mode == REL_ARRIVAL) && pick_st;

    mro_inflight_ctr #(.MAX(QSIZE), .W(CNT_W)) u_ld_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (iss_fire && (iss_is_store == KIND_LOAD)),
        .dec   (ret_fire && (ret_is_store == KIND_LOAD)),
        .cnt   (ld_inflight)
    );

    mro_inflight_ctr #(.MAX(QSIZE), .W(CNT_W)) u_st_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (iss_fire && (iss_is_store == KIND_STORE)),
        .dec   (ret_fire && (ret_is_store == KIND_STORE)),
        .cnt   (st_inflight)
    );

    // Sticky flag for responses that match nothing outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_unknown_tag <= 1'b0;
        end else if (rsp_valid && !rsp_hit) begin
            err_unknown_tag <= 1'b1;
        end
    end

    // Last retired number, kept only for the program-order check.
    logic [SEQ_W-1:0] last_ret;
    logic             any_ret;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ret <= '0;
            any_ret  <= 1'b0;
        end else if (ret_fire) begin
            last_ret <= ret_seq;
            any_ret  <= 1'b1;
        end
    end

    p_program_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REL_PROGRAM && ret_fire && any_ret) |-> (ret_seq == SEQ_W'(last_ret + 1'b1)));
    p_retire_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_seq)));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_unknown_tag |=> err_unknown_tag);
    p_issue_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(ld_inflight) + SUM_W'(st_inflight)) <= SUM_W'(QSIZE));
    p_single_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_ld, push_st}) <= 1);
endmodule

// File: tb/tb_mem_resp_orderer.sv
module tb_mem_resp_orderer;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W      = 6;
    localparam int QSIZE      = 4;
    localparam int ORD_DEPTH  = 4;
    localparam int CNT_W      = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_in_order;
    logic             iss_valid;
    logic [SEQ_W-1:0] iss_seq;
    logic             iss_is_store;
    logic [CNT_W-1:0] iss_pend;
    logic             iss_ready;
    logic             rsp_valid;
    logic [SEQ_W-1:0] rsp_seq;
    logic             rsp_ld_ready, rsp_st_ready;
    logic             ret_valid, ret_ready, ret_is_store;
    logic [SEQ_W-1:0] ret_seq;
    logic [CNT_W-1:0] ld_inflight, st_inflight;
    logic             err_unknown_tag;

    int checks = 0;
    int errors = 0;
    int nseq   = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_resp_orderer #(.SEQ_W(SEQ_W), .QSIZE(QSIZE), .ORD_DEPTH(ORD_DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_in_order(cfg_in_order),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_is_store(iss_is_store),
        .iss_pend(iss_pend), .iss_ready(iss_ready),
        .rsp_valid(rsp_valid), .rsp_seq(rsp_seq),
        .rsp_ld_ready(rsp_ld_ready), .rsp_st_ready(rsp_st_ready),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_seq(ret_seq),
        .ret_is_store(ret_is_store), .ld_inflight(ld_inflight),
        .st_inflight(st_inflight), .err_unknown_tag(err_unknown_tag)
    );

    // Program-order vector: inputs for one cycle, outputs expected before its edge.
    typedef struct packed {
        logic             iss_v;
        logic             iss_st;
        logic             rsp_v;
        logic [SEQ_W-1:0] rsp_s;
        logic             ret_rdy;
        logic             exp_v;
        logic [SEQ_W-1:0] exp_s;
        logic [2:0]       exp_ld;
        logic [2:0]       exp_st;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 3'd0, 3'd0},
        {1'b1, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 3'd1, 3'd0},
        {1'b1, 1'b0, 1'b1, 6'd1, 1'b0, 1'b0, 6'd0, 3'd1, 3'd1},
        {1'b0, 1'b0, 1'b1, 6'd2, 1'b0, 1'b0, 6'd0, 3'd2, 3'd1},
        {1'b0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 6'd0, 3'd2, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 6'd0, 3'd2, 3'd1},
        {1'b1, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 6'd1, 3'd1, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 6'd2, 3'd1, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 3'd0, 3'd1},
        {1'b0, 1'b0, 1'b1, 6'd3, 1'b0, 1'b0, 6'd0, 3'd0, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 3'd0, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 6'd3, 3'd0, 3'd1},
        {1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 3'd0, 3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_is_store = 1'b0; iss_seq = '0; iss_pend = '0;
        rsp_valid = 1'b0; rsp_seq = '0; ret_ready = 1'b0;
    endtask

    task automatic adv();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic in_order);
        idle();
        cfg_in_order = in_order;
        rst_n = 1'b0;
        adv(); adv();
        rst_n = 1'b1;
        nseq = 0;
        #1;
    endtask

    task automatic issue(input logic st);
        iss_valid = 1'b1; iss_is_store = st; iss_seq = SEQ_W'(nseq);
        adv();
        iss_valid = 1'b0;
        nseq++;
    endtask

    task automatic respond(input int s);
        rsp_valid = 1'b1; rsp_seq = SEQ_W'(s);
        adv();
        rsp_valid = 1'b0;
    endtask

    task automatic retire_chk(input string req, input int s, input int st);
        ret_ready = 1'b1;
        #1;
        chk({req, " ret_valid"}, int'(ret_valid), 1);
        chk({req, " ret_seq"}, int'(ret_seq), s);
        chk({req, " ret_is_store"}, int'(ret_is_store), st);
        adv();
        ret_ready = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_in_order = 1'b1;
        idle();
        @(negedge clk);

        // R1: reset state
        do_reset(1'b1);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 ld_inflight", int'(ld_inflight), 0);
        chk("R1 st_inflight", int'(st_inflight), 0);
        chk("R1 err", int'(err_unknown_tag), 0);
        chk("R1 iss_ready", int'(iss_ready), 1);
        chk("R1 rsp_ld_ready", int'(rsp_ld_ready), 1);
        chk("R1 rsp_st_ready", int'(rsp_st_ready), 1);

        // R3 R4 R7 R9: program-order vector walk
        for (int i = 0; i < NVEC; i++) begin
            iss_valid    = VEC[i].iss_v;
            iss_is_store = VEC[i].iss_st;
            iss_seq      = SEQ_W'(nseq);
            rsp_valid    = VEC[i].rsp_v;
            rsp_seq      = VEC[i].rsp_s;
            ret_ready    = VEC[i].ret_rdy;
            #1;
            chk($sformatf("R3/R4 row%0d ret_valid", i), int'(ret_valid), int'(VEC[i].exp_v));
            if (VEC[i].exp_v) begin
                chk($sformatf("R3 R9 row%0d ret_seq", i), int'(ret_seq), int'(VEC[i].exp_s));
            end
            chk($sformatf("R7 row%0d ld_inflight", i), int'(ld_inflight), int'(VEC[i].exp_ld));
            chk($sformatf("R7 row%0d st_inflight", i), int'(st_inflight), int'(VEC[i].exp_st));
            adv();
            if (VEC[i].iss_v) nseq++;
        end
        idle();

        // R8: unknown tag, then duplicate response
        do_reset(1'b1);
        respond(9);
        #1;
        chk("R8 unknown err", int'(err_unknown_tag), 1);
        chk("R8 unknown ret_valid", int'(ret_valid), 0);
        chk("R8 unknown ld_inflight", int'(ld_inflight), 0);
        do_reset(1'b1);
        chk("R1 err cleared", int'(err_unknown_tag), 0);
        issue(1'b0);
        respond(0);
        #1;
        chk("R8 valid rsp no err", int'(err_unknown_tag), 0);
        respond(0);
        #1;
        chk("R8 duplicate err", int'(err_unknown_tag), 1);
        retire_chk("R8 single entry", 0, 0);
        #1;
        chk("R8 no second copy", int'(ret_valid), 0);
        adv(); adv();
        #1;
        chk("R8 sticky", int'(err_unknown_tag), 1);

        // R5 R2: arrival order across kinds, and reservation gate
        do_reset(1'b0);
        issue(1'b0); issue(1'b1); issue(1'b0);
        iss_pend = 3'd1;
        #1;
        chk("R2 pend blocks", int'(iss_ready), 0);
        iss_pend = 3'd0;
        #1;
        chk("R2 pend cleared", int'(iss_ready), 1);
        issue(1'b1);
        #1;
        chk("R2 full blocks", int'(iss_ready), 0);
        respond(3); respond(0); respond(2); respond(1);
        retire_chk("R5 first", 3, 1);
        retire_chk("R5 second", 0, 0);
        retire_chk("R5 third", 2, 0);
        retire_chk("R5 fourth", 1, 1);
        #1;
        chk("R5 drained", int'(ret_valid), 0);

        // R6: load FIFO full
        do_reset(1'b0);
        for (int k = 0; k < QSIZE; k++) issue(1'b0);
        for (int k = 0; k < QSIZE; k++) respond(k);
        #1;
        chk("R6 ld full", int'(rsp_ld_ready), 0);
        chk("R6 st free", int'(rsp_st_ready), 1);
        retire_chk("R6 pop", 0, 0);
        #1;
        chk("R6 ld room again", int'(rsp_ld_ready), 1);

        // R10: next sequence entry still held by an old request
        do_reset(1'b0);
        for (int k = 0; k < QSIZE; k++) issue(1'b0);
        respond(1); respond(2); respond(3);
        retire_chk("R10 drain a", 1, 0);
        retire_chk("R10 drain b", 2, 0);
        retire_chk("R10 drain c", 3, 0);
        #1;
        chk("R10 ld_inflight", int'(ld_inflight), 1);
        chk("R10 slot busy", int'(iss_ready), 0);
        respond(0);
        retire_chk("R10 old", 0, 0);
        #1;
        chk("R10 slot free", int'(iss_ready), 1);
        issue(1'b1);
        #1;
        chk("R10 wrapped issue", int'(st_inflight), 1);

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule